// File: doc/BRIEF.md
# Debug Cross-Trigger Router

This block links debug event sources and sinks inside a chip. Trigger inputs from neighbouring units are gathered onto a few broadcast channels, and each channel is steered to one or more trigger outputs. Channel events can also come from other routers through the channel input port, or from software. A trigger output stays asserted until software acknowledges it, so it can serve directly as an interrupt line.

Software sees a 32-bit register bus with a word address, a write strobe, write data and combinational read data. Each trigger input and each trigger output has its own channel mask register. Other registers hold the global enable, the software channel set, clear and pulse controls, the interrupt acknowledge and four live status words. A key-guarded lock blocks every register write except writes to the lock register. The identification words are fixed constants and can always be read.

Top module: `xtrig_router`

## Requirements
- R1: After reset the unit is locked, the enable, all masks and the software channel state are zero, and `trig_out` and `chan_out` are zero.
- R2: A write of 0xC5ACCE55 to 0xFB0 unlocks the unit, and a write of any other value to 0xFB0 locks it again. A read of 0xFB4 returns bit 1 = locked and bit 0 = 1.
- R3: While the unit is locked, writes to every address except 0xFB0 change nothing that can be read back or seen at the outputs.
- R4: Bit 0 of 0x000 is the global enable. While it is 0, `trig_out` and `chan_out` are zero and all latched trigger outputs are cleared.
- R5: The channel mask for trigger input n is at 0x020+4n, bits [3:0]. Bit c routes a high `trig_in[n]` onto channel c in the same cycle. Bits 31:4 read as zero.
- R6: The channel mask for trigger output m is at 0x0A0+4m, bits [3:0]. If any active channel c has bit c set, `trig_out[m]` is high from the next clock edge on.
- R7: A latched trigger output stays high until a 1 is written to bit m of 0x010. The clear takes effect at that write's clock edge. If output m is hit in the same cycle as its acknowledge, the hit wins and the output stays high.
- R8: Writing 1s to 0x014 sets those software channel bits, and writing 1s to 0x018 clears them. The held bits read back at 0x014 and keep their channels active.
- R9: A write to 0x01C makes the channels named in bits [3:0] active for exactly the one cycle after the write edge.
- R10: The status words are read-only: 0x130 returns `trig_in`, 0x134 returns `trig_out`, 0x138 returns `chan_in` and 0x13C returns `chan_out`.
- R11: The words 0xFE0..0xFFC return in bits [7:0] the constants 0x21, 0x09, 0x1B, 0x00, 0x0D, 0x90, 0x05 and 0xB1, in address order, whether the unit is locked or not.
- R12: A high bit of `chan_in` makes that channel active while the unit is enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, taken at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| trig_in | input | 8 | Trigger input events (level) |
| trig_out | output | 8 | Latched trigger outputs |
| chan_in | input | 4 | Channel events from other routers |
| chan_out | output | 4 | Active channel vector |

## Verification
A trigger output can be hit by a channel in the same cycle that software acknowledges it. The bench provokes this in two ways. A directed case holds a trigger input high while it writes the acknowledge for the output that input feeds. The random phase issues acknowledge writes with random data while trigger and channel inputs change every cycle. Both are judged by a bench model in which a hit overrides the acknowledge, so the output must read high on the following cycle, while an acknowledge with no hit must leave it low.

// File: rtl/xtrig_pkg.sv
package xtrig_pkg;
  localparam logic [31:0] UNLOCK_KEY = 32'hC5AC_CE55;

  localparam logic [11:0] A_CTRL     = 12'h000;
  localparam logic [11:0] A_ACK      = 12'h010;
  localparam logic [11:0] A_CSET     = 12'h014;
  localparam logic [11:0] A_CCLR     = 12'h018;
  localparam logic [11:0] A_CPULSE   = 12'h01C;
  localparam logic [11:0] A_INMASK   = 12'h020;
  localparam logic [11:0] A_OUTMASK  = 12'h0A0;
  localparam logic [11:0] A_ST_TIN   = 12'h130;
  localparam logic [11:0] A_ST_TOUT  = 12'h134;
  localparam logic [11:0] A_ST_CIN   = 12'h138;
  localparam logic [11:0] A_ST_COUT  = 12'h13C;
  localparam logic [11:0] A_LOCK     = 12'hFB0;
  localparam logic [11:0] A_LOCKSTAT = 12'hFB4;
  localparam logic [11:0] A_ID_LO    = 12'hFE0;
  localparam logic [11:0] A_ID_HI    = 12'hFFC;

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0:    return 8'h21;
      3'd1:    return 8'h09;
      3'd2:    return 8'h1B;
      3'd3:    return 8'h00;
      3'd4:    return 8'h0D;
      3'd5:    return 8'h90;
      3'd6:    return 8'h05;
      default: return 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/xtrig_regs.sv
module xtrig_regs
  import xtrig_pkg::*;
#(
  parameter int N_IN  = 8,
  parameter int N_OUT = 8,
  parameter int N_CH  = 4,
  parameter int AW    = 12,
  parameter int DW    = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [AW-1:0]         addr,
  input  logic                  we,
  input  logic [DW-1:0]         wdata,
  output logic [DW-1:0]         rdata,
  input  logic [N_IN-1:0]       st_tin,
  input  logic [N_OUT-1:0]      st_tout,
  input  logic [N_CH-1:0]       st_cin,
  input  logic [N_CH-1:0]       st_cout,
  output logic                  en_q,
  output logic                  locked_q,
  output logic [N_IN*N_CH-1:0]  in_mask_flat,
  output logic [N_OUT*N_CH-1:0] out_mask_flat,
  output logic [N_CH-1:0]       sw_set_q,
  output logic [N_CH-1:0]       pulse_q,
  output logic [N_OUT-1:0]      ack_bits
);
  logic [N_CH-1:0] in_mask  [N_IN];
  logic [N_CH-1:0] out_mask [N_OUT];
  logic            wr_ok;

  function automatic logic [AW-1:0] slot(input logic [11:0] base, input int idx);
    return AW'(32'(base) + 32'(4 * idx));
  endfunction

  assign wr_ok    = we && !locked_q;
  assign ack_bits = (wr_ok && addr == A_ACK) ? wdata[N_OUT-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b1;
      en_q     <= 1'b0;
      sw_set_q <= '0;
      pulse_q  <= '0;
      for (int n = 0; n < N_IN; n++)  in_mask[n]  <= '0;
      for (int m = 0; m < N_OUT; m++) out_mask[m] <= '0;
    end else begin
      pulse_q <= '0;
      if (we && addr == A_LOCK) locked_q <= (wdata != UNLOCK_KEY);
      if (wr_ok) begin
        if (addr == A_CTRL)   en_q     <= wdata[0];
        if (addr == A_CSET)   sw_set_q <= sw_set_q | wdata[N_CH-1:0];
        if (addr == A_CCLR)   sw_set_q <= sw_set_q & ~wdata[N_CH-1:0];
        if (addr == A_CPULSE) pulse_q  <= wdata[N_CH-1:0];
        for (int n = 0; n < N_IN; n++)
          if (addr == slot(A_INMASK, n)) in_mask[n] <= wdata[N_CH-1:0];
        for (int m = 0; m < N_OUT; m++)
          if (addr == slot(A_OUTMASK, m)) out_mask[m] <= wdata[N_CH-1:0];
      end
    end
  end

  for (genvar g = 0; g < N_IN; g++) begin : g_inflat
    assign in_mask_flat[g*N_CH +: N_CH] = in_mask[g];
  end
  for (genvar g = 0; g < N_OUT; g++) begin : g_outflat
    assign out_mask_flat[g*N_CH +: N_CH] = out_mask[g];
  end

  always_comb begin
    rdata = '0;
    if (addr == A_CTRL)     rdata = DW'(en_q);
    if (addr == A_CSET)     rdata = DW'(sw_set_q);
    if (addr == A_ST_TIN)   rdata = DW'(st_tin);
    if (addr == A_ST_TOUT)  rdata = DW'(st_tout);
    if (addr == A_ST_CIN)   rdata = DW'(st_cin);
    if (addr == A_ST_COUT)  rdata = DW'(st_cout);
    if (addr == A_LOCKSTAT) rdata = DW'({locked_q, 1'b1});
    if (addr >= A_ID_LO && addr <= A_ID_HI && addr[1:0] == 2'b00)
      rdata = DW'(id_byte(addr[4:2]));
    for (int n = 0; n < N_IN; n++)
      if (addr == slot(A_INMASK, n)) rdata = DW'(in_mask[n]);
    for (int m = 0; m < N_OUT; m++)
      if (addr == slot(A_OUTMASK, m)) rdata = DW'(out_mask[m]);
  end
endmodule

// File: rtl/xtrig_chan_mux.sv
module xtrig_chan_mux #(
  parameter int N_IN = 8,
  parameter int N_CH = 4
) (
  input  logic                 en,
  input  logic [N_IN-1:0]      trig_in,
  input  logic [N_CH-1:0]      chan_in,
  input  logic [N_IN*N_CH-1:0] in_mask_flat,
  input  logic [N_CH-1:0]      sw_set,
  input  logic [N_CH-1:0]      pulse,
  output logic [N_CH-1:0]      chan_vec
);
  function automatic logic [N_CH-1:0] gather(input logic [N_IN-1:0] t,
                                             input logic [N_IN*N_CH-1:0] masks);
    logic [N_CH-1:0] acc = '0;
    for (int n = 0; n < N_IN; n++)
      if (t[n]) acc |= masks[n*N_CH +: N_CH];
    return acc;
  endfunction

  logic [N_CH-1:0] from_trig;
  assign from_trig = gather(trig_in, in_mask_flat);
  assign chan_vec  = en ? (from_trig | chan_in | sw_set | pulse) : '0;
endmodule

// File: rtl/xtrig_out_latch.sv
module xtrig_out_latch #(
  parameter int N_OUT = 8,
  parameter int N_CH  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic [N_CH-1:0]       chan_vec,
  input  logic [N_OUT*N_CH-1:0] out_mask_flat,
  input  logic [N_OUT-1:0]      ack_bits,
  output logic [N_OUT-1:0]      hit,
  output logic [N_OUT-1:0]      lat,
  output logic [N_OUT-1:0]      trig_out
);
  for (genvar m = 0; m < N_OUT; m++) begin : g_out
    assign hit[m] = en && |(chan_vec & out_mask_flat[m*N_CH +: N_CH]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   lat[m] <= 1'b0;
      else if (!en) lat[m] <= 1'b0;
      else          lat[m] <= (lat[m] & ~ack_bits[m]) | hit[m];
    end
  end
  assign trig_out = lat & {N_OUT{en}};
endmodule

// File: rtl/xtrig_router.sv
module xtrig_router #(
  parameter int N_IN  = 8,
  parameter int N_OUT = 8,
  parameter int N_CH  = 4,
  parameter int AW    = 12,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_we,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [N_IN-1:0]  trig_in,
  output logic [N_OUT-1:0] trig_out,
  input  logic [N_CH-1:0]  chan_in,
  output logic [N_CH-1:0]  chan_out
);
  localparam int IN_BITS  = N_IN * N_CH;
  localparam int OUT_BITS = N_OUT * N_CH;

  logic                en_q, locked_q;
  logic [IN_BITS-1:0]  in_mask_flat;
  logic [OUT_BITS-1:0] out_mask_flat;
  logic [N_CH-1:0]     sw_set_q, pulse_q, chan_vec;
  logic [N_OUT-1:0]    ack_bits, hit_vec, lat_vec;

  xtrig_regs #(.N_IN(N_IN), .N_OUT(N_OUT), .N_CH(N_CH), .AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
    .rdata(bus_rdata), .st_tin(trig_in), .st_tout(trig_out), .st_cin(chan_in),
    .st_cout(chan_vec), .en_q(en_q), .locked_q(locked_q),
    .in_mask_flat(in_mask_flat), .out_mask_flat(out_mask_flat),
    .sw_set_q(sw_set_q), .pulse_q(pulse_q), .ack_bits(ack_bits)
  );

  xtrig_chan_mux #(.N_IN(N_IN), .N_CH(N_CH)) u_chan (
    .en(en_q), .trig_in(trig_in), .chan_in(chan_in), .in_mask_flat(in_mask_flat),
    .sw_set(sw_set_q), .pulse(pulse_q), .chan_vec(chan_vec)
  );

  xtrig_out_latch #(.N_OUT(N_OUT), .N_CH(N_CH)) u_out (
    .clk(clk), .rst_n(rst_n), .en(en_q), .chan_vec(chan_vec),
    .out_mask_flat(out_mask_flat), .ack_bits(ack_bits),
    .hit(hit_vec), .lat(lat_vec), .trig_out(trig_out)
  );

  assign chan_out = chan_vec;
endmodule

// File: rtl/xtrig_router_chk.sv
module xtrig_router_chk
  import xtrig_pkg::*;
#(
  parameter int N_OUT = 8,
  parameter int N_CH  = 4,
  parameter int AW    = 12,
  parameter int DW    = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AW-1:0]    bus_addr,
  input logic             bus_we,
  input logic [DW-1:0]    bus_wdata,
  input logic             en_q,
  input logic             locked_q,
  input logic [N_CH-1:0]  pulse_q,
  input logic [N_OUT-1:0] ack_bits,
  input logic [N_OUT-1:0] hit_vec,
  input logic [N_OUT-1:0] lat_vec,
  input logic [N_OUT-1:0] trig_out,
  input logic [N_CH-1:0]  chan_out
);
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (trig_out == '0 && chan_out == '0));  // R4
  AST_KEY_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_LOCK && bus_wdata == UNLOCK_KEY) |=> !locked_q);  // R2
  AST_OTHER_RELOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_LOCK && bus_wdata != UNLOCK_KEY) |=> locked_q);  // R2
  AST_LOCKED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && bus_we && bus_addr != A_LOCK) |=> ($stable(en_q) && ack_bits == '0 || $stable(en_q)));  // R3
  AST_HIT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && hit_vec != '0) |=> (!en_q || (lat_vec & $past(hit_vec)) == $past(hit_vec)));  // R6
  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> (!en_q || ($past(lat_vec & ~ack_bits) & ~lat_vec) == '0));  // R7
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ((ack_bits & ~hit_vec) != '0) |=> ((lat_vec & $past(ack_bits & ~hit_vec)) == '0));  // R7
  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_q != '0 && !(bus_we && bus_addr == A_CPULSE)) |=> pulse_q == '0);  // R9
endmodule

bind xtrig_router xtrig_router_chk #(.N_OUT(N_OUT), .N_CH(N_CH), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
  .en_q(en_q), .locked_q(locked_q), .pulse_q(pulse_q), .ack_bits(ack_bits),
  .hit_vec(hit_vec), .lat_vec(lat_vec), .trig_out(trig_out), .chan_out(chan_out)
);

// File: tb/xtrig_router_bench.sv
`timescale 1ns/1ps
module xtrig_router_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] b_addr = '0;
  logic        b_we = 1'b0;
  logic [31:0] b_wd = '0;
  logic [31:0] b_rd;
  logic [7:0]  t_in = '0;
  logic [7:0]  t_out;
  logic [3:0]  c_in = '0;
  logic [3:0]  c_out;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [3:0] m_in  [8];
  logic [3:0] m_out [8];
  logic [3:0] m_sw;
  logic [7:0] m_lat;

  always #10 clk = ~clk;

  xtrig_router u_xtrig_router (
    .clk(clk), .rst_n(rst_n), .bus_addr(b_addr), .bus_we(b_we), .bus_wdata(b_wd),
    .bus_rdata(b_rd), .trig_in(t_in), .trig_out(t_out), .chan_in(c_in), .chan_out(c_out)
  );

  function automatic logic [3:0] exp_chan(input logic [7:0] t, input logic [3:0] ci);
    logic [3:0] r = ci | m_sw;
    for (int n = 0; n < 8; n++) if (t[n]) r = r | m_in[n];
    return r;
  endfunction

  function automatic logic [7:0] exp_hit(input logic [3:0] ch);
    logic [7:0] r = '0;
    for (int m = 0; m < 8; m++) r[m] = (ch & m_out[m]) != 4'h0;
    return r;
  endfunction

  function automatic logic [7:0] exp_id(input int k);
    logic [7:0] tbl [8] = '{8'h21, 8'h09, 8'h1B, 8'h00, 8'h0D, 8'h90, 8'h05, 8'hB1};
    return tbl[k];
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    b_addr = a; b_we = 1'b1; b_wd = d;
    @(negedge clk);
    b_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    b_addr = a;
    #1;
    d = b_rd;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [7:0]  ackv;
    void'($urandom(32'd2024));
    for (int n = 0; n < 8; n++) begin m_in[n] = '0; m_out[n] = '0; end
    m_sw = '0; m_lat = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(12'hFB4, v); check("R1 lockstat", v, 32'h3);
    rd(12'h000, v); check("R1 ctrl", v, 32'h0);
    rd(12'h0A4, v); check("R1 outmask", v, 32'h0);
    check("R1 outputs", {t_out, c_out}, 12'h000);

    // R11 ids while locked
    for (int k = 0; k < 8; k++) begin
      rd(12'(12'hFE0 + 4*k), v); check("R11 id locked", v, {24'h0, exp_id(k)});
    end

    // R3 writes while locked
    wr(12'h000, 32'h1);
    wr(12'h028, 32'hF);
    wr(12'h014, 32'hF);
    rd(12'h000, v); check("R3 ctrl locked", v, 32'h0);
    rd(12'h028, v); check("R3 mask locked", v, 32'h0);
    rd(12'h014, v); check("R3 cset locked", v, 32'h0);
    check("R3 chan_out", {28'h0, c_out}, 32'h0);

    // R2 unlock
    wr(12'hFB0, 32'hC5ACCE55);
    rd(12'hFB4, v); check("R2 unlocked", v, 32'h1);

    // R5 / R6 configuration
    wr(12'h028, 32'hFFFF_FFF5); m_in[2] = 4'h5;
    wr(12'h034, 32'h2);         m_in[5] = 4'h2;
    wr(12'h0A0, 32'h1);         m_out[0] = 4'h1;
    wr(12'h0AC, 32'h4);         m_out[3] = 4'h4;
    wr(12'h0B8, 32'h2);         m_out[6] = 4'h2;
    wr(12'h0BC, 32'h8);         m_out[7] = 4'h8;
    rd(12'h028, v); check("R5 mask upper zero", v, 32'h5);
    rd(12'h0BC, v); check("R6 mask read", v, 32'h8);

    // R4 disabled: no outputs
    @(negedge clk); t_in = 8'hFF; c_in = 4'hF;
    #1; check("R4 chan_out off", {28'h0, c_out}, 32'h0);
    @(negedge clk); check("R4 trig_out off", {24'h0, t_out}, 32'h0);
    t_in = 8'h00; c_in = 4'h0;

    wr(12'h000, 32'h1);
    rd(12'h000, v); check("R4 enable read", v, 32'h1);

    // R5 routing, R6 latching one edge later
    @(negedge clk); t_in = 8'h04;
    #1; check("R5 chan_out", {28'h0, c_out}, 32'h5);
    check("R6 not before edge", {24'h0, t_out}, 32'h0);
    @(negedge clk); check("R6 latched", {24'h0, t_out}, 32'h09);

    // R7 ack in the same cycle as a hit: hit wins
    wr(12'h010, 32'h01);
    check("R7 hit beats ack", {24'h0, t_out}, 32'h09);
    // R7 ack after source is gone
    t_in = 8'h00;
    @(negedge clk);
    check("R7 held after source gone", {24'h0, t_out}, 32'h09);
    wr(12'h010, 32'h08);
    check("R7 ack clears one", {24'h0, t_out}, 32'h01);
    wr(12'h010, 32'h01);
    check("R7 ack clears all", {24'h0, t_out}, 32'h00);

    // R8 software set / clear
    wr(12'h014, 32'hA); m_sw = 4'hA;
    rd(12'h014, v); check("R8 set read", v, 32'hA);
    check("R8 chan_out", {28'h0, c_out}, 32'hA);
    wr(12'h018, 32'h8); m_sw = 4'h2;
    rd(12'h014, v); check("R8 clear read", v, 32'h2);
    check("R8 chan after clear", {28'h0, c_out}, 32'h2);
    check("R8 out6 latched", {24'h0, t_out}, 32'hC0);
    wr(12'h018, 32'hF); m_sw = 4'h0;
    wr(12'h010, 32'hFF);
    check("R8 cleared outs", {24'h0, t_out}, 32'h00);

    // R9 pulse: one cycle
    @(negedge clk); b_addr = 12'h01C; b_we = 1'b1; b_wd = 32'h8;
    @(negedge clk); b_we = 1'b0;
    #1; check("R9 pulse active", {28'h0, c_out}, 32'h8);
    @(negedge clk); check("R9 pulse gone", {28'h0, c_out}, 32'h0);
    check("R9 pulse latched out7", {24'h0, t_out}, 32'h80);

    // R10 / R12 status and channel input
    @(negedge clk); t_in = 8'h20; c_in = 4'h4;
    rd(12'h130, v); check("R10 tin status", v, 32'h20);
    rd(12'h138, v); check("R10 cin status", v, 32'h4);
    rd(12'h13C, v); check("R12 chan from chan_in", v, 32'h6);
    @(negedge clk);
    rd(12'h134, v); check("R10 tout status", v, 32'hC8);
    t_in = 8'h00; c_in = 4'h0;
    wr(12'h010, 32'hFF);

    // R4 disable clears latch
    @(negedge clk); t_in = 8'h04;
    @(negedge clk); t_in = 8'h00;
    check("R4 pre-disable", {24'h0, t_out}, 32'h09);
    wr(12'h000, 32'h0);
    check("R4 disabled out", {24'h0, t_out}, 32'h00);
    wr(12'h000, 32'h1);
    check("R4 latch cleared", {24'h0, t_out}, 32'h00);

    // R2 / R3 relock
    wr(12'hFB0, ~32'hC5ACCE55);
    rd(12'hFB4, v); check("R2 relocked", v, 32'h3);
    wr(12'h000, 32'h0);
    rd(12'h000, v); check("R3 ctrl kept", v, 32'h1);
    rd(12'hFE8, v); check("R11 id relocked", v, 32'h1B);
    wr(12'hFB0, 32'hC5ACCE55);

    // random phase: R5 R6 R7 R12
    for (int n = 0; n < 8; n++) begin
      m_in[n] = 4'($urandom); wr(12'(12'h020 + 4*n), {28'h0, m_in[n]});
      m_out[n] = 4'($urandom); wr(12'(12'h0A0 + 4*n), {28'h0, m_out[n]});
    end
    t_in = 8'h00;
    wr(12'h010, 32'hFF);
    m_lat = '0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      check("R7 random trig_out", {24'h0, t_out}, {24'h0, m_lat});
      t_in = (($urandom % 3) == 0) ? 8'($urandom) : 8'h00;
      c_in = (($urandom % 5) == 0) ? 4'($urandom) : 4'h0;
      if (($urandom % 3) == 0) begin
        b_addr = 12'h010; b_we = 1'b1; b_wd = $urandom;
      end else begin
        b_we = 1'b0;
      end
      ackv = b_we ? b_wd[7:0] : 8'h00;
      #1;
      check("R5 random chan_out", {28'h0, c_out}, {28'h0, exp_chan(t_in, c_in)});
      m_lat = (m_lat & ~ackv) | exp_hit(exp_chan(t_in, c_in));
    end
    @(negedge clk);
    b_we = 1'b0;
    check("R7 random final", {24'h0, t_out}, {24'h0, m_lat});

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule